// File: doc/BRIEF.md
# Paced Peripheral-to-Memory Byte Mover

This block copies bytes between one peripheral data register and system memory without processor help. Software loads a transfer setup: source address, destination address, byte count, direction and pacing mode. After that, the peripheral's request line controls the pace. Before it touches the shared bus, the engine raises a bus request and waits for the grant. Each byte takes two bus accesses: a read from the source, then a write of the same value to the destination.

There are two pacing modes. In single mode, every rising edge of the request line moves exactly one byte, and the bus is handed back after each byte. In burst mode, the engine keeps the bus and moves bytes back to back for as long as the request line stays high. When the count runs out, the engine releases the bus, sets a sticky done flag and gives a one-cycle interrupt pulse.

The bus side uses a valid/ready handshake. An access is pending while `bus_valid` is high and completes on a cycle where `bus_ready` is also high. Until that cycle the engine holds the address, write enable and write data unchanged, so a slow target applies back-pressure just by holding `bus_ready` low. Read data must be valid in the cycle the read completes.

Top module: `dma_pacer`

## Requirements
- R1: A load pulse is taken only when the engine is idle; a load pulse while a transfer is in progress changes neither the addresses used nor the remaining count.
- R2: The engine raises `bus_req` before any access and drives `bus_valid` only while `bus_gnt` is high; no access starts before the grant.
- R3: Each byte is a read at the source, followed by a write of the unchanged value to the destination. `cfg_dir`=0 moves from the device to memory; `cfg_dir`=1 moves from memory to the device.
- R4: The memory-side address grows by one after each byte. The device-side address stays at its loaded value for the whole transfer.
- R5: With `cfg_burst`=0, one byte moves for each rising edge of `dev_req`, and `bus_req` is low in the cycle after that byte's write completes.
- R6: A rising edge of `dev_req` that arrives while the engine is waiting for the grant is remembered, and its byte still moves once the grant comes.
- R7: With `cfg_burst`=1, bytes move back to back while `dev_req` is high, and `bus_req` stays high for the whole burst.
- R8: In burst mode, if `dev_req` is low when a byte's write completes, the engine releases the bus with bytes still owed. It resumes when `dev_req` is high again.
- R9: When the last byte's write completes, the engine drops `bus_req`, sets `done` and pulses `irq` high for exactly one cycle. `done` stays high until the next accepted load clears it.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_we` and `bus_wdata` hold steady.
- R11: A load with a byte count of zero sets `done` and pulses `irq` without raising `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load pulse for the setup fields |
| cfg_dir | input | 1 | 0: device to memory, 1: memory to device |
| cfg_burst | input | 1 | 0: one byte per request edge, 1: burst while request is high |
| cfg_src | input | AW | Source address |
| cfg_dst | input | AW | Destination address |
| cfg_count | input | CW | Number of bytes to move |
| dev_req | input | 1 | Peripheral request line |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_valid | output | 1 | Access pending on the bus |
| bus_ready | input | 1 | Target accepts or completes the access |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid when a read completes |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Once the engine is idle, a load takes effect at the next edge. A zero-count load has `done` and `irq` high after that same edge. A request edge raises `bus_req` two edges later, and `bus_valid` comes up on the edge after the grant. Each byte then takes at least two further handshake cycles, plus one for every cycle `bus_ready` is held low. The bench drives inputs on falling edges, gives each request a fixed window longer than the slowest byte with wait states, and reads outputs and monitor counters on a falling edge after that window. Pass/fail is based on monitor counts of completed writes, `bus_req` rises and `irq` pulses, together with memory and device contents, rather than exact edge positions.

// File: rtl/dma_pacer_pkg.sv
package dma_pacer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAITG,
    ST_RD,
    ST_WR
  } dma_st_e;
endpackage

// File: rtl/dma_req_edge.sv
module dma_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= req;
      // a new edge wins over a clear in the same cycle
      pend_q <= (req & ~prev_q) | (pend_q & ~clr);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          cfg_dir,
  input  logic          cfg_burst,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          dir,
  output logic          burst,
  output logic          last
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] ADR_ONE = AW'(1);

  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          dir_q, burst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      burst_q <= 1'b0;
    end else if (load) begin
      src_q   <= cfg_src;
      dst_q   <= cfg_dst;
      cnt_q   <= cfg_count;
      dir_q   <= cfg_dir;
      burst_q <= cfg_burst;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_ONE;
      if (dir_q) src_q <= src_q + ADR_ONE;
      else       dst_q <= dst_q + ADR_ONE;
    end
  end

  assign src   = src_q;
  assign dst   = dst_q;
  assign dir   = dir_q;
  assign burst = burst_q;
  assign last  = (cnt_q == CNT_ONE);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q != '0));

  // R4
  fixed_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (dir_q ? $stable(dst_q) : $stable(src_q)));
endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
  import dma_pacer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    cfg_zero,
  input  logic    burst,
  input  logic    req_lvl,
  input  logic    pend,
  input  logic    last,
  input  logic    gnt,
  input  logic    ready,
  output dma_st_e st,
  output logic    load_acc,
  output logic    take,
  output logic    step,
  output logic    bus_req,
  output logic    done,
  output logic    irq
);
  dma_st_e st_q, st_d;
  logic    done_q, irq_q;
  logic    finish;

  assign load_acc = load && (st_q == ST_IDLE);
  assign take     = (st_q == ST_WAITG) && gnt;
  assign step     = (st_q == ST_WR) && ready;
  assign finish   = (load_acc && cfg_zero) || (step && last);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (load_acc && !cfg_zero) st_d = ST_ARM;
      ST_ARM:   if (burst ? req_lvl : pend) st_d = ST_WAITG;
      ST_WAITG: if (gnt) st_d = ST_RD;
      ST_RD:    if (ready) st_d = ST_WR;
      ST_WR:
        if (ready) begin
          if (last)                 st_d = ST_IDLE;
          else if (burst && req_lvl) st_d = ST_RD;
          else                      st_d = ST_ARM;
        end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= finish;
      if (finish)        done_q <= 1'b1;
      else if (load_acc) done_q <= 1'b0;
    end
  end

  assign st      = st_q;
  assign bus_req = (st_q == ST_WAITG) || (st_q == ST_RD) || (st_q == ST_WR);
  assign done    = done_q;
  assign irq     = irq_q;

  // R5
  edge_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR && ready && !burst) |=> !bus_req);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R2
  grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (st_q == ST_WAITG));
endmodule

// File: rtl/dma_pacer.sv
module dma_pacer
  import dma_pacer_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_dir,
  input  logic          cfg_burst,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic          dev_req,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          irq
);
  dma_st_e       st;
  logic          load_acc, take, step, pend;
  logic          dir, burst, last;
  logic [AW-1:0] src, dst;
  logic [DW-1:0] hold_q;

  dma_req_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (dev_req),
    .clr   (take | load_acc),
    .pend  (pend)
  );

  dma_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_acc),
    .step      (step),
    .cfg_dir   (cfg_dir),
    .cfg_burst (cfg_burst),
    .cfg_src   (cfg_src),
    .cfg_dst   (cfg_dst),
    .cfg_count (cfg_count),
    .src       (src),
    .dst       (dst),
    .dir       (dir),
    .burst     (burst),
    .last      (last)
  );

  dma_ctrl_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .cfg_zero (cfg_count == '0),
    .burst    (burst),
    .req_lvl  (dev_req),
    .pend     (pend),
    .last     (last),
    .gnt      (bus_gnt),
    .ready    (bus_ready),
    .st       (st),
    .load_acc (load_acc),
    .take     (take),
    .step     (step),
    .bus_req  (bus_req),
    .done     (done),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                       hold_q <= '0;
    else if (st == ST_RD && bus_ready) hold_q <= bus_rdata;
  end

  assign bus_valid = (st == ST_RD) || (st == ST_WR);
  assign bus_we    = (st == ST_WR);
  assign bus_addr  = bus_we ? dst : src;
  assign bus_wdata = hold_q;

  // R2
  valid_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_gnt);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata)));

  // R3
  dir_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && !dir) |-> $stable(src));
endmodule

// File: tb/dma_pacer_test.sv
module dma_pacer_test;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int DW = 8;
  localparam logic [AW-1:0] DEV = 16'hF000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0, cfg_dir = 1'b0, cfg_burst = 1'b0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          dev_req = 1'b0;
  logic          bus_req, bus_valid, bus_we, done, irq;
  logic          bus_gnt, bus_ready;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  logic          hold_gnt = 1'b0;
  logic          ws_on = 1'b0;

  always #5 clk = ~clk;

  dma_pacer #(.AW(AW), .CW(CW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_dir(cfg_dir),
    .cfg_burst(cfg_burst), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .dev_req(dev_req), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .irq(irq)
  );

  // bus, memory, device and monitor model
  logic [7:0]  mem [256];
  logic [7:0]  dev_log [64];
  logic [7:0]  dev_rd_val;
  int          dev_wr_n, bytes_w, req_rise, irq_n, stray;
  logic        req_prev, tick;

  function automatic logic [7:0] patt(input int a);
    return 8'((a * 7) + 3);
  endfunction

  assign bus_ready = ws_on ? tick : 1'b1;
  assign bus_rdata = (bus_addr == DEV) ? dev_rd_val : mem[bus_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= patt(i);
      dev_rd_val <= 8'hC0;
      dev_wr_n <= 0; bytes_w <= 0; req_rise <= 0; irq_n <= 0; stray <= 0;
      req_prev <= 1'b0; tick <= 1'b0; bus_gnt <= 1'b0;
    end else begin
      tick     <= ~tick;
      bus_gnt  <= bus_req & ~hold_gnt;
      req_prev <= bus_req;
      if (bus_req && !req_prev) req_rise <= req_rise + 1;
      if (irq) irq_n <= irq_n + 1;
      if (bus_valid && bus_addr != DEV && bus_addr[15:8] != 8'h00) stray <= stray + 1;
      if (bus_valid && bus_ready) begin
        if (bus_we) begin
          bytes_w <= bytes_w + 1;
          if (bus_addr == DEV) begin
            dev_log[dev_wr_n[5:0]] <= bus_wdata;
            dev_wr_n <= dev_wr_n + 1;
          end else mem[bus_addr[7:0]] <= bus_wdata;
        end else if (bus_addr == DEV) dev_rd_val <= dev_rd_val + 8'd1;
      end
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input bit dir, input bit bst, input logic [AW-1:0] s,
                      input logic [AW-1:0] d, input int n);
    @(negedge clk);
    cfg_dir = dir; cfg_burst = bst; cfg_src = s; cfg_dst = d;
    cfg_count = CW'(n); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); dev_req = 1'b1;
    @(negedge clk); dev_req = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  // {ws, dir, burst, count[7:0], base[7:0]}
  localparam logic [18:0] VEC [4] = '{
    {1'b0, 1'b0, 1'b0, 8'd3, 8'h10},
    {1'b1, 1'b1, 1'b0, 8'd2, 8'h40},
    {1'b0, 1'b0, 1'b1, 8'd5, 8'h20},
    {1'b1, 1'b1, 1'b1, 8'd4, 8'h60}
  };

  int b0, r0, i0, w0, n, bad, moved;
  logic [7:0] d0, base;
  bit vdir, vbst;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_req == 1'b0, "R2 reset bus_req", bus_req, 0);
    check(bus_valid == 1'b0, "R2 reset bus_valid", bus_valid, 0);
    check(done == 1'b0, "R9 reset done", done, 0);
    check(irq == 1'b0, "R9 reset irq", irq, 0);

    for (int v = 0; v < 4; v++) begin
      ws_on = VEC[v][18]; vdir = VEC[v][17]; vbst = VEC[v][16];
      n = int'(VEC[v][15:8]); base = VEC[v][7:0];
      b0 = bytes_w; r0 = req_rise; i0 = irq_n; w0 = dev_wr_n; d0 = dev_rd_val;
      if (vdir) load(1'b1, vbst, {8'h00, base}, DEV, n);
      else      load(1'b0, vbst, DEV, {8'h00, base}, n);
      check(done == 1'b0, "R9 done cleared by load", done, 0);
      if (vbst) begin
        @(negedge clk); dev_req = 1'b1;
        for (int t = 0; t < 300 && !done; t++) @(negedge clk);
        dev_req = 1'b0;
      end else begin
        for (int k = 0; k < n; k++) pulse_req();
      end
      repeat (4) @(negedge clk);
      check(done == 1'b1, "R9 done after transfer", done, 1);
      check(bytes_w - b0 == n, vbst ? "R7 burst byte count" : "R5 edge byte count", bytes_w - b0, n);
      check(req_rise - r0 == (vbst ? 1 : n), vbst ? "R7 one bus hold" : "R5 release per byte",
            req_rise - r0, vbst ? 1 : n);
      check(irq_n - i0 == 1, "R9 single irq", irq_n - i0, 1);
      bad = 0;
      for (int k = 0; k < n; k++) begin
        if (vdir) begin
          if (dev_log[(w0 + k) % 64] != patt(int'(base) + k)) bad++;
        end else if (mem[8'(base + 8'(k))] != 8'(d0 + 8'(k))) bad++;
      end
      check(bad == 0, ws_on ? "R10 R3 R4 data with wait states" : "R3 R4 data order", bad, 0);
    end

    // R6: edge latched while waiting for grant
    b0 = bytes_w; ws_on = 1'b0; hold_gnt = 1'b1;
    load(1'b0, 1'b0, DEV, 16'h00C0, 1);
    @(negedge clk); dev_req = 1'b1;
    @(negedge clk); dev_req = 1'b0;
    repeat (10) @(negedge clk);
    check(bus_req == 1'b1 && bus_valid == 1'b0, "R6 R2 waiting for grant", bus_valid, 0);
    check(bytes_w == b0, "R2 no access before grant", bytes_w - b0, 0);
    hold_gnt = 1'b0;
    repeat (10) @(negedge clk);
    check(bytes_w - b0 == 1 && done, "R6 latched edge moved byte", bytes_w - b0, 1);

    // R8 and R1: burst paused by request low, load during pause ignored
    b0 = bytes_w; r0 = req_rise; d0 = dev_rd_val;
    load(1'b0, 1'b1, DEV, 16'h0080, 6);
    @(negedge clk); dev_req = 1'b1;
    repeat (7) @(negedge clk); dev_req = 1'b0;
    repeat (10) @(negedge clk);
    moved = bytes_w - b0;
    check(bus_req == 1'b0 && done == 1'b0, "R8 bus released mid burst", bus_req, 0);
    check(moved >= 1 && moved < 6, "R8 partial burst", moved, 3);
    load(1'b0, 1'b1, DEV, 16'h00A0, 1);
    repeat (3) @(negedge clk);
    check(done == 1'b0 && bus_req == 1'b0, "R1 load ignored while busy", done, 0);
    dev_req = 1'b1;
    for (int t = 0; t < 300 && !done; t++) @(negedge clk);
    dev_req = 1'b0;
    repeat (3) @(negedge clk);
    check(bytes_w - b0 == 6, "R8 resumed to full count", bytes_w - b0, 6);
    check(req_rise - r0 == 2, "R8 two bus holds", req_rise - r0, 2);
    bad = 0;
    for (int k = 0; k < 6; k++) if (mem[8'h80 + k] != 8'(d0 + 8'(k))) bad++;
    check(bad == 0, "R1 R4 contiguous destination", bad, 0);
    check(mem[8'hA0] == patt(8'hA0), "R1 ignored address untouched", mem[8'hA0], patt(8'hA0));

    // R11: zero count
    r0 = req_rise; i0 = irq_n;
    load(1'b0, 1'b0, DEV, 16'h00D0, 0);
    check(done == 1'b1 && irq == 1'b1, "R11 zero count done", done, 1);
    repeat (5) @(negedge clk);
    check(req_rise == r0, "R11 no bus request", req_rise - r0, 0);
    check(irq_n - i0 == 1, "R11 one irq", irq_n - i0, 1);
    check(stray == 0, "R4 device address fixed", stray, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule